// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two N-bit two's complement numbers over several clock cycles and returns the full 2N-bit signed product. A start pulse, given while the block is idle, captures both operands. The block then runs one recoding step per cycle. Each step looks at the low bit of the multiplier register together with a trailing bit. That pair decides whether the stored multiplicand is added to a running accumulator, subtracted from it, or left out. The step then shifts the accumulator, the multiplier and the trailing bit right by one place as a single arithmetic shift.

After exactly N steps, the upper half of the product is in the accumulator and the lower half is in the multiplier register. The block copies them into a product register and pulses `done`. Negative operands need no extra correction pass. The accumulator carries one guard bit, so subtracting the most negative multiplicand cannot wrap. A host drives `start`, waits for `done`, and then reads `product`, which keeps its value until the next operation completes.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its outputs: after that edge `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` high at an edge where `busy` is 0 sets `busy` to 1 after that edge and captures `mcand` and `mplier`.
- R3: Take the edge that accepts `start` as edge 0. Edges 1 to N perform the N steps. After edge N, `busy` is 0 and `done` is 1 for exactly one cycle.
- R4: A `start` given while `busy` is 1 has no effect: the running operation keeps its operands and its completion cycle.
- R5: When `done` is 1, `product` equals the signed product of the captured operands as a 2N-bit two's complement value. This holds for every sign combination, including both operands equal to -2^(N-1). For N=4, 7 times 3 gives 8'h15.
- R6: `product` changes only at the edge that raises `done`. It holds its value while idle and throughout a later operation.
- R7: Changes on `mcand` and `mplier` while `busy` is 1 do not affect the result.
- R8: The recoding of the pair (multiplier low bit, trailing bit) works as follows: 1,0 subtracts the multiplicand, 0,1 adds it, and 0,0 or 1,1 only shifts. As a result, a multiplier of all ones gives the negated multiplicand and a multiplier of zero gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; taken only when idle |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Registered signed product |

## Verification
The bench builds the block twice. The instance with N=8 takes constrained random operand pairs together with directed corners: both operands at -128, an all-ones multiplier, zero, and alternating bit patterns. It also raises `start` and alters the operands in the middle of a run. The instance with N=4 is small enough to cover all 256 operand pairs, including the guard-bit case -8 times -8.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    STEP_SKIP = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic  q0,
  input  logic  qm1,
  output step_e op
);
  // Pair of current low bit and trailing bit selects the step action.
  always_comb begin
    unique case ({q0, qm1})
      2'b10:   op = STEP_SUB;
      2'b01:   op = STEP_ADD;
      default: op = STEP_SKIP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  step_e        op,
  output logic [W-1:0] sum
);
  always_comb begin
    unique case (op)
      STEP_ADD: sum = acc + addend;
      STEP_SUB: sum = acc - addend;
      default:  sum = acc;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

  logic [CW-1:0] step_cnt;

  assign load = start && !busy;
  assign last = busy && (step_cnt == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int AW = N + 1;  // guard bit keeps A - (-2^(N-1)) in range

  logic [AW-1:0] acc_q, acc_n, sum, mcand_ext;
  logic [N-1:0]  mreg_q, qreg_q, qreg_n;
  logic          qm1_q, qm1_n;
  logic          load, last;
  step_e         op;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done),
    .load (load),
    .last (last)
  );

  booth_recode u_recode (
    .q0 (qreg_q[0]),
    .qm1(qm1_q),
    .op (op)
  );

  assign mcand_ext = {mreg_q[N-1], mreg_q};

  booth_addsub #(.W(AW)) u_addsub (
    .acc   (acc_q),
    .addend(mcand_ext),
    .op    (op),
    .sum   (sum)
  );

  // Arithmetic right shift of {sum, Q, Q-1} as one register.
  assign acc_n  = {sum[AW-1], sum[AW-1:1]};
  assign qreg_n = {sum[0], qreg_q[N-1:1]};
  assign qm1_n  = qreg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mreg_q  <= '0;
      qreg_q  <= '0;
      qm1_q   <= 1'b0;
      product <= '0;
    end else if (load) begin
      acc_q  <= '0;
      mreg_q <= mcand;
      qreg_q <= mplier;
      qm1_q  <= 1'b0;
    end else if (busy) begin
      acc_q  <= acc_n;
      qreg_q <= qreg_n;
      qm1_q  <= qm1_n;
      if (last) product <= {acc_n[N-1:0], qreg_n};
    end
  end
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int KW = $clog2(N + 1) + 1;

  logic [KW-1:0]          busy_cycles;
  logic [N-1:0]           cap_a, cap_b;
  logic signed [2*N-1:0]  ext_a, ext_b, exp_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cycles <= '0;
      cap_a       <= '0;
      cap_b       <= '0;
    end else if (start && !busy) begin
      busy_cycles <= '0;
      cap_a       <= mcand;
      cap_b       <= mplier;
    end else if (busy) begin
      busy_cycles <= busy_cycles + 1'b1;
    end
  end

  assign ext_a = {{N{cap_a[N-1]}}, cap_a};
  assign ext_b = {{N{cap_b[N-1]}}, cap_b};
  assign exp_p = ext_a * ext_b;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_n_steps_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && busy_cycles == KW'(N)));

  assert_busy_ends_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_product_value_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == exp_p));

  assert_product_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .mcand  (mcand),
  .mplier (mplier),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // 8-bit instance
  logic        start8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy8, done8;
  logic [15:0] p8;

  booth_seq_mul #(.N(8)) u0 (
    .clk(clk), .rst(rst), .start(start8), .mcand(a8), .mplier(b8),
    .busy(busy8), .done(done8), .product(p8)
  );

  // 4-bit instance for exhaustive coverage
  logic       start4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4;
  logic [7:0] p4;

  booth_seq_mul #(.N(4)) u1 (
    .clk(clk), .rst(rst), .start(start4), .mcand(a4), .mplier(b4),
    .busy(busy4), .done(done4), .product(p4)
  );

  function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
    logic signed [15:0] sx, sy;
    sx = {{8{x[7]}}, x};
    sy = {{8{y[7]}}, y};
    return sx * sy;
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
    logic signed [7:0] sx, sy;
    sx = {{4{x[3]}}, x};
    sy = {{4{y[3]}}, y};
    return sx * sy;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Full-timing operation on the 8-bit instance. disturb: 0 none,
  // 1 extra start mid-run (R4), 2 operand changes mid-run (R7).
  task automatic op8(input logic [7:0] x, input logic [7:0] y, input int disturb,
                     input string req);
    logic [15:0] prev, expv;
    prev = p8;
    expv = ref8(x, y);
    @(negedge clk);
    a8 = x; b8 = y; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    chk(busy8 == 1'b1, "R2", busy8, 1);
    for (int k = 2; k <= 8; k++) begin
      if (disturb == 1 && k == 4) start8 = 1'b1;
      if (disturb == 1 && k == 5) start8 = 1'b0;
      if (disturb == 2) begin a8 = ~x + 8'(k); b8 = y ^ 8'hA5; end
      @(negedge clk);
      if (done8 !== 1'b0) chk(1'b0, "R3", done8, 0);
      if (p8 !== prev) chk(1'b0, "R6", p8, prev);
    end
    start8 = 1'b0;
    @(negedge clk);
    chk(done8 == 1'b1 && busy8 == 1'b0, "R3", {done8, busy8}, 2'b10);
    chk(p8 == expv, req, p8, expv);
    @(negedge clk);
    chk(done8 == 1'b0, "R3", done8, 0);
    chk(busy8 == 1'b0, "R4", busy8, 0);
    repeat (2) @(negedge clk);
    chk(p8 == expv, "R6", p8, expv);
  endtask

  task automatic op4(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] expv;
    expv = ref4(x, y);
    @(negedge clk);
    a4 = x; b4 = y; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk(done4 == 1'b1 && p4 == expv, "R5", p4, expv);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(busy8 == 0 && done8 == 0 && p8 == 0, "R1", {busy8, done8, p8}, 0);
    chk(busy4 == 0 && done4 == 0 && p4 == 0, "R1", {busy4, done4, p4}, 0);
    rst = 1'b0;

    // R5 worked example on the 4-bit instance
    op4(4'd7, 4'd3);
    chk(p4 == 8'h15, "R5", p4, 8'h15);

    // directed corners on the 8-bit instance
    op8(8'h80, 8'h80, 0, "R5");     // -128 * -128 = 16384
    op8(8'h80, 8'h7F, 0, "R5");
    op8(8'h7F, 8'h80, 0, "R5");
    op8(8'h25, 8'hFF, 0, "R8");     // all-ones multiplier negates
    op8(8'h80, 8'hFF, 0, "R8");
    op8(8'h5A, 8'h00, 0, "R8");     // zero multiplier
    op8(8'h13, 8'h55, 0, "R8");     // alternating pairs: add/sub each step
    op8(8'hE3, 8'hAA, 0, "R8");
    op8(8'h7E, 8'h7E, 1, "R4");     // start while busy ignored
    op8(8'h91, 8'h3C, 2, "R7");     // operand changes while busy ignored

    // constrained random: bias some operands to extremes
    for (int i = 0; i < 600; i++) begin
      logic [7:0] x, y;
      x = 8'($urandom);
      y = 8'($urandom);
      if (($urandom % 8) == 0) x = (($urandom % 2) == 0) ? 8'h80 : 8'h7F;
      if (($urandom % 8) == 0) y = (($urandom % 2) == 0) ? 8'h80 : 8'hFF;
      op8(x, y, int'($urandom % 3), "R5");
    end

    // exhaustive 4-bit
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        op4(4'(i), 4'(j));

    // R1 mid-operation reset
    @(negedge clk);
    a8 = 8'h33; b8 = 8'h44; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(busy8 == 0 && done8 == 0 && p8 == 0, "R1", {busy8, done8, p8}, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule